// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the first byte seen after a START (or repeated START) selects this device as a slave. It takes a byte that serial capture logic has already assembled, and a strobe that marks the byte as complete. It compares that byte with a programmed own-address register. The comparison uses either the 7-bit format (upper seven bits only) or the first byte of the 10-bit format (all eight bits). An all-zero byte is recognised as a general call.

On a hit, the block sets a registered addressed-as-slave flag. It sets a general-call flag as well when the byte was a general call. When the direction-follow mode is active, it also loads a transfer-direction bit from the received read/write bit. The flags are registered on the strobe edge, so the ACK logic can read them before the acknowledge clock.

The block has no effect while the interface is disabled or the device is acting as bus master. Bit capture and ACK driving belong to neighbouring logic.

Top module: `slv_addr_match`

## Requirements
- R1: With `fmt10_i`=0, a first byte whose bits [7:1] equal `own_addr_i[7:1]` sets `addressed_o`. Bit 0 of both values is ignored.
- R2: With `fmt10_i`=1, `addressed_o` sets only when all eight bits of the first byte equal `own_addr_i`.
- R3: A first byte of 8'h00 sets both `gcall_o` and `addressed_o`, in either format.
- R4: `gcall_o` is 0 in the cycle after a `start_i` or `stop_i` pulse.
- R5: When `addr_only_i`=0 and the first byte hits (own match or general call), `tx_dir_o` takes bit 0 of that byte (1 = transmit, 0 = receive). When `addr_only_i`=1, `tx_dir_o` is not loaded.
- R6: `tx_dir_o` is 0 in the cycle after a `start_i` or `stop_i` pulse.
- R7: A `dsr_wr_i` pulse clears `addressed_o`. If a hit is registered in the same cycle, the hit wins.
- R8: Only the first completed byte after each START is an address. Later bytes, and bytes after a STOP without a new START, leave all three flags unchanged. A repeated START re-arms the window.
- R9: Flags update on the clock edge that samples `byte_done_i`, and are visible from the cycle after the strobe.
- R10: While `master_i`=1, a completed address byte changes no flag. While `en_i`=0, all flags are held at 0.
- R11: After reset, `addressed_o`, `gcall_o` and `tx_dir_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Interface enable; 0 clears all flags |
| master_i | input | 1 | Device is acting as bus master |
| start_i | input | 1 | One-cycle START / repeated START strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| byte_done_i | input | 1 | One-cycle strobe: `rx_byte_i` is complete |
| rx_byte_i | input | BYTE_W | Received byte, read/write bit in bit 0 |
| own_addr_i | input | BYTE_W | Own-address register |
| fmt10_i | input | 1 | 0 = 7-bit compare, 1 = 10-bit first-byte compare |
| addr_only_i | input | 1 | 1 = do not load direction from the read/write bit |
| dsr_wr_i | input | 1 | Write strobe to the data shift register |
| addressed_o | output | 1 | Addressed-as-slave flag |
| gcall_o | output | 1 | General-call flag |
| tx_dir_o | output | 1 | Transfer direction, 1 = transmit |

## Verification
The bench builds the block with `BYTE_W`=8 and both the general-call and 10-bit compare variants enabled. It sweeps all 256 first-byte values in both formats and both direction modes. It does this for two own addresses, one with bit 0 set and one with bit 0 clear. That covers:
- the single-bit difference between the 7-bit and 10-bit compares;
- the overlap of general call with a real address;
- every read/write value.

Directed sequences add same-cycle write/hit collisions, bytes outside the address window, and the master and disabled cases.

// File: rtl/slv_match_pkg.sv
package slv_match_pkg;

   // Combined compare result of one candidate address byte
   typedef struct packed {
      logic hit;     // own address or general call
      logic gcall;   // all-zero byte
      logic rw;      // read/write bit of the byte
   } match_res_t;

   localparam int unsigned MIN_BYTE_W = 2;

endpackage

// File: rtl/slv_first_byte_win.sv
module slv_first_byte_win (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic start_i,
   input  logic stop_i,
   input  logic byte_done_i,
   output logic armed_o,
   output logic addr_byte_o
);

   logic armed_q;

   // A byte completing in a START/STOP cycle is not an address byte
   assign addr_byte_o = armed_q & byte_done_i & ~start_i & ~stop_i;
   assign armed_o     = armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (!en_i) begin
         armed_q <= 1'b0;
      end else if (start_i) begin
         armed_q <= 1'b1;
      end else if (stop_i || byte_done_i) begin
         armed_q <= 1'b0;
      end
   end

   // R8
   win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done_i && !start_i) |=> !armed_q);

endmodule

// File: rtl/slv_addr_cmp.sv
module slv_addr_cmp
   import slv_match_pkg::*;
#(
   parameter int unsigned BYTE_W     = 8,
   parameter bit          GCALL_EN   = 1'b1,
   parameter bit          TEN_BIT_EN = 1'b1
) (
   input  logic [BYTE_W-1:0] rx_byte_i,
   input  logic [BYTE_W-1:0] own_addr_i,
   input  logic              fmt10_i,
   output match_res_t        res_o
);

   localparam int unsigned ADDR_W = BYTE_W - 1;

   if (BYTE_W < MIN_BYTE_W) begin : g_bad_width
      $error("slv_addr_cmp: BYTE_W too small");
   end

   logic short_hit;
   logic long_hit;
   logic gc_hit;

   assign short_hit = (rx_byte_i[BYTE_W-1 -: ADDR_W] == own_addr_i[BYTE_W-1 -: ADDR_W]);

   if (TEN_BIT_EN) begin : g_long
      assign long_hit = (rx_byte_i == own_addr_i);
   end else begin : g_no_long
      logic unused_fmt;
      assign unused_fmt = fmt10_i ^ own_addr_i[0];
      assign long_hit   = 1'b0;
   end

   if (GCALL_EN) begin : g_gcall
      assign gc_hit = (rx_byte_i == '0);
   end else begin : g_no_gcall
      assign gc_hit = 1'b0;
   end

   logic own_hit;
   assign own_hit = (TEN_BIT_EN && fmt10_i) ? long_hit : short_hit;

   assign res_o.hit   = own_hit | gc_hit;
   assign res_o.gcall = gc_hit;
   assign res_o.rw    = rx_byte_i[0];

endmodule

// File: rtl/slv_match_flags.sv
module slv_match_flags
   import slv_match_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       master_i,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       addr_byte_i,
   input  logic       dsr_wr_i,
   input  logic       addr_only_i,
   input  match_res_t res_i,
   output logic       addressed_o,
   output logic       gcall_o,
   output logic       tx_dir_o
);

   logic take;
   logic set_addr;

   assign take     = addr_byte_i & en_i & ~master_i;
   assign set_addr = take & res_i.hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addressed_o <= 1'b0;
      end else if (!en_i) begin
         addressed_o <= 1'b0;
      end else if (set_addr) begin
         addressed_o <= 1'b1;
      end else if (dsr_wr_i) begin
         addressed_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcall_o <= 1'b0;
      end else if (!en_i || start_i || stop_i) begin
         gcall_o <= 1'b0;
      end else if (take && res_i.gcall) begin
         gcall_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_dir_o <= 1'b0;
      end else if (!en_i || start_i || stop_i) begin
         tx_dir_o <= 1'b0;
      end else if (set_addr && !addr_only_i) begin
         tx_dir_o <= res_i.rw;
      end
   end

   // R3
   gcall_implies_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gcall_o) |-> addressed_o);

   // R4
   gcall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i || stop_i) |=> !gcall_o);

   // R6
   txdir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i || stop_i) |=> !tx_dir_o);

   // R7
   wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dsr_wr_i && !(addr_byte_i && res_i.hit)) |=> !addressed_o);

   // R10
   disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!addressed_o && !gcall_o && !tx_dir_o));

   // R10
   master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (master_i && en_i && !dsr_wr_i && !start_i && !stop_i) |=> $stable({addressed_o, gcall_o, tx_dir_o}));

endmodule

// File: rtl/slv_addr_match.sv
module slv_addr_match
   import slv_match_pkg::*;
#(
   parameter int unsigned BYTE_W     = 8,
   parameter bit          GCALL_EN   = 1'b1,
   parameter bit          TEN_BIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              master_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              byte_done_i,
   input  logic [BYTE_W-1:0] rx_byte_i,
   input  logic [BYTE_W-1:0] own_addr_i,
   input  logic              fmt10_i,
   input  logic              addr_only_i,
   input  logic              dsr_wr_i,
   output logic              addressed_o,
   output logic              gcall_o,
   output logic              tx_dir_o
);

   if (BYTE_W < MIN_BYTE_W) begin : g_bad_width
      $error("slv_addr_match: BYTE_W too small");
   end

   logic       armed;
   logic       addr_byte;
   match_res_t res;

   slv_first_byte_win u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en_i),
      .start_i     (start_i),
      .stop_i      (stop_i),
      .byte_done_i (byte_done_i),
      .armed_o     (armed),
      .addr_byte_o (addr_byte)
   );

   slv_addr_cmp #(
      .BYTE_W     (BYTE_W),
      .GCALL_EN   (GCALL_EN),
      .TEN_BIT_EN (TEN_BIT_EN)
   ) u_cmp (
      .rx_byte_i  (rx_byte_i),
      .own_addr_i (own_addr_i),
      .fmt10_i    (fmt10_i),
      .res_o      (res)
   );

   slv_match_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en_i),
      .master_i    (master_i),
      .start_i     (start_i),
      .stop_i      (stop_i),
      .addr_byte_i (addr_byte),
      .dsr_wr_i    (dsr_wr_i),
      .addr_only_i (addr_only_i),
      .res_i       (res),
      .addressed_o (addressed_o),
      .gcall_o     (gcall_o),
      .tx_dir_o    (tx_dir_o)
   );

   // R8
   late_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done_i && !armed && en_i && !dsr_wr_i && !start_i && !stop_i)
      |=> $stable({addressed_o, gcall_o, tx_dir_o}));

endmodule

// File: tb/slv_addr_match_tb.sv
module slv_addr_match_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0;
   logic       master_i = 1'b0;
   logic       start_i = 1'b0;
   logic       stop_i = 1'b0;
   logic       byte_done_i = 1'b0;
   logic [7:0] rx_byte_i = '0;
   logic [7:0] own_addr_i = '0;
   logic       fmt10_i = 1'b0;
   logic       addr_only_i = 1'b0;
   logic       dsr_wr_i = 1'b0;
   logic       addressed_o;
   logic       gcall_o;
   logic       tx_dir_o;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   slv_addr_match #(.BYTE_W(8), .GCALL_EN(1'b1), .TEN_BIT_EN(1'b1)) dut_i (
      .clk (clk), .rst_n (rst_n), .en_i (en_i), .master_i (master_i),
      .start_i (start_i), .stop_i (stop_i), .byte_done_i (byte_done_i),
      .rx_byte_i (rx_byte_i), .own_addr_i (own_addr_i), .fmt10_i (fmt10_i),
      .addr_only_i (addr_only_i), .dsr_wr_i (dsr_wr_i),
      .addressed_o (addressed_o), .gcall_o (gcall_o), .tx_dir_o (tx_dir_o)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0b expected=%0b (own=%h rx=%h fmt10=%0b ao=%0b)",
                  req, what, act, exp, own_addr_i, rx_byte_i, fmt10_i, addr_only_i);
      end
   endtask

   task automatic do_start();
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
   endtask
   task automatic do_stop();
      stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
   endtask
   task automatic do_byte(input logic [7:0] b);
      rx_byte_i = b; byte_done_i = 1'b1; @(negedge clk); byte_done_i = 1'b0;
   endtask
   task automatic do_wr();
      dsr_wr_i = 1'b1; @(negedge clk); dsr_wr_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired before the test sequence ended");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] owns [2];
      owns[0] = 8'hA4;
      owns[1] = 8'h3B;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "addressed", addressed_o, 1'b0);
      chk("R11", "gcall", gcall_o, 1'b0);
      chk("R11", "tx_dir", tx_dir_o, 1'b0);
      rst_n = 1'b1;
      en_i  = 1'b1;
      @(negedge clk);

      // Exhaustive first-byte sweep
      for (int o = 0; o < 2; o++) begin
         for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < 2; a++) begin
               for (int v = 0; v < 256; v++) begin
                  logic [7:0] b;
                  logic gc, own, hit, txe;
                  b = v[7:0];
                  own_addr_i  = owns[o];
                  fmt10_i     = f[0];
                  addr_only_i = a[0];
                  gc  = (b == 8'h00);
                  own = f[0] ? (b == owns[o]) : (b[7:1] == owns[o][7:1]);
                  hit = gc | own;
                  txe = hit & ~a[0] & b[0];
                  do_start();
                  do_byte(b);
                  chk(f[0] ? "R2" : "R1", "addressed", addressed_o, hit);
                  chk("R3", "gcall", gcall_o, gc);
                  chk("R5", "tx_dir", tx_dir_o, txe);
                  // second byte: an all-zero or matching byte must be ignored
                  do_byte(v[0] ? 8'h00 : owns[o]);
                  chk("R8", "addressed after 2nd byte", addressed_o, hit);
                  chk("R8", "gcall after 2nd byte", gcall_o, gc);
                  chk("R8", "tx_dir after 2nd byte", tx_dir_o, txe);
                  do_stop();
                  chk("R4", "gcall after stop", gcall_o, 1'b0);
                  chk("R6", "tx_dir after stop", tx_dir_o, 1'b0);
                  do_wr();
                  chk("R7", "addressed after write", addressed_o, 1'b0);
               end
            end
         end
      end

      own_addr_i  = 8'h3B;
      fmt10_i     = 1'b0;
      addr_only_i = 1'b0;

      // R9: not visible before the edge, visible after it
      do_start();
      rx_byte_i = 8'h3B; byte_done_i = 1'b1;
      #1;
      chk("R9", "addressed before edge", addressed_o, 1'b0);
      @(negedge clk); byte_done_i = 1'b0;
      chk("R9", "addressed after edge", addressed_o, 1'b1);
      chk("R9", "tx_dir after edge", tx_dir_o, 1'b1);

      // R4/R6 via repeated START; R8 re-arm with general call
      do_start();
      chk("R4", "gcall after restart", gcall_o, 1'b0);
      chk("R6", "tx_dir after restart", tx_dir_o, 1'b0);
      do_byte(8'h00);
      chk("R8", "gcall after re-arm", gcall_o, 1'b1);

      // R7: write and hit in the same cycle, hit wins
      do_wr();
      chk("R7", "addressed cleared", addressed_o, 1'b0);
      do_start();
      rx_byte_i = 8'h3A; byte_done_i = 1'b1; dsr_wr_i = 1'b1;
      @(negedge clk); byte_done_i = 1'b0; dsr_wr_i = 1'b0;
      chk("R7", "hit beats write", addressed_o, 1'b1);
      do_wr();

      // R8: byte after STOP without START is ignored
      do_stop();
      do_byte(8'h00);
      chk("R8", "gcall after stop-byte", gcall_o, 1'b0);
      chk("R8", "addressed after stop-byte", addressed_o, 1'b0);

      // R10: master ignores a matching address byte
      master_i = 1'b1;
      do_start();
      do_byte(8'h3B);
      chk("R10", "addressed as master", addressed_o, 1'b0);
      chk("R10", "tx_dir as master", tx_dir_o, 1'b0);
      master_i = 1'b0;

      // R10: disable clears flags and blocks matching
      do_start();
      do_byte(8'h00);
      chk("R10", "gcall before disable", gcall_o, 1'b1);
      en_i = 1'b0;
      @(negedge clk);
      chk("R10", "addressed when disabled", addressed_o, 1'b0);
      chk("R10", "gcall when disabled", gcall_o, 1'b0);
      do_start();
      do_byte(8'h3B);
      chk("R10", "no match when disabled", addressed_o, 1'b0);
      en_i = 1'b1;

      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule